// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the 32-bit time-of-day reference for a serial bus whose isochronous traffic is divided into 125 µs cycles. The value is made of three counting fields that carry into one another. The lowest field counts ticks of a 24.576 MHz reference. The middle field counts whole cycles. The top field counts seconds. The block is clocked by a faster system clock and advances only on cycles where the reference tick enable is high.

A node acting as cycle master reads the current value from a dedicated output and places it in each outgoing cycle-start packet. A node that is not master overwrites its whole value with the payload of every received cycle-start packet. Between such reloads the timer keeps counting on its own while the run enable is set.

An alternative timing mode lets an external 8 kHz tick mark the cycle boundaries instead of the internal wrap. Software can overwrite the whole value at any time. A one-clock strobe marks each cycle boundary.

Top module: `iso_cycle_timer`

## Requirements
- R1: While reset is asserted, and until the first update after it, `timer` reads 0 and `cyc_strobe` is 0.
- R2: The offset field, `timer[11:0]`, increases by one on each clock where counting is active and `tick_en` is 1. It holds on clocks where `tick_en` is 0.
- R3: When counting is active, external mode is off and `tick_en` meets an offset of 3071 (or more), the offset becomes 0 and the cycle field, `timer[24:12]`, advances by one. `cyc_strobe` is 1 in the one clock where the zeroed offset first shows.
- R4: When the cycle field advances from 7999 (or more), it becomes 0 and the seconds field, `timer[31:25]`, advances by one.
- R5: When the seconds field advances from 127, it becomes 0.
- R6: With `run_en` at 0 and no load, `timer` holds its value whatever `tick_en` and `ext_tick` do.
- R7: When `master_mode` is 0 and `rx_cs_valid` is 1, the next `timer` value equals `rx_cs_data`. This happens whether `run_en` is 0 or 1.
- R8: When `master_mode` is 1, `rx_cs_valid` has no effect. `tx_cs_data` equals `timer` while `master_mode` is 1 and is 0 otherwise.
- R9: With `ext_mode` at 1 and counting active, `ext_tick` zeroes the offset, advances the cycle field and raises `cyc_strobe` for one clock. It wins over `tick_en` in the same clock. `tick_en` alone then increases the offset but holds it at 3071 without any carry.
- R10: `sw_wr` loads `sw_data` into the next `timer` value and takes priority over a cycle-start reload. A cycle-start reload takes priority over counting. `cyc_strobe` is 0 after any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock pulse per 24.576 MHz reference tick |
| run_en | input | 1 | Allows free counting between loads |
| master_mode | input | 1 | Node is cycle master |
| ext_mode | input | 1 | Cycle boundaries come from `ext_tick` |
| ext_tick | input | 1 | One-clock pulse per external 8 kHz tick |
| rx_cs_valid | input | 1 | Received cycle-start payload is valid |
| rx_cs_data | input | 32 | Received cycle-start payload |
| sw_wr | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write value |
| timer | output | 32 | Current value: seconds [31:25], cycle [24:12], offset [11:0] |
| tx_cs_data | output | 32 | Value for the outgoing cycle-start packet when master |
| cyc_strobe | output | 1 | One-clock cycle-boundary strobe |

## Verification
Sparse and back-to-back reference ticks separate plain offset counting from holding. Loads placed just below each field limit show whether carries ripple through one field, two fields or all three. Cycle-start payloads are offered both as master and as non-master, with the run enable on and off, to tell a reload apart from an ignored packet. External-tick sequences that collide with reference ticks show the zeroing, the saturation at 3071 and the priority between the two sources. Same-clock collisions of software writes, reloads and ticks pin down the priority order.

// File: rtl/iso_ct_pkg.sv
package iso_ct_pkg;
  // Source of the next timer value, lowest priority first
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_COUNT = 2'd1,
    SRC_RX    = 2'd2,
    SRC_SW    = 2'd3
  } ct_src_e;
endpackage

// File: rtl/iso_ct_stage.sv
// One modular counting field: advance, wrap with carry, optional hold at top,
// or forced clear that counts as a boundary.
module iso_ct_stage #(
  parameter int MOD = 3072,
  localparam int W = $clog2(MOD)
) (
  input  logic [W-1:0] cur,
  input  logic         inc,
  input  logic         clr,
  input  logic         sat,
  output logic [W-1:0] nxt,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_comb begin
    nxt   = cur;
    carry = 1'b0;
    if (clr) begin
      nxt   = '0;
      carry = 1'b1;
    end else if (inc) begin
      if (cur >= LAST) begin
        if (!sat) begin
          nxt   = '0;
          carry = 1'b1;
        end
      end else begin
        nxt = cur + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iso_ct_sel.sv
// Priority selection of the next-value source.
module iso_ct_sel
  import iso_ct_pkg::*;
(
  input  logic    sw_wr,
  input  logic    rx_valid,
  input  logic    master,
  input  logic    run_en,
  output ct_src_e src
);
  always_comb begin
    if (sw_wr)                   src = SRC_SW;
    else if (rx_valid && !master) src = SRC_RX;
    else if (run_en)             src = SRC_COUNT;
    else                         src = SRC_HOLD;
  end
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer
  import iso_ct_pkg::*;
#(
  parameter int OFF_MOD = 3072,
  parameter int CNT_MOD = 8000,
  parameter int SEC_MOD = 128,
  localparam int OFF_W = $clog2(OFF_MOD),
  localparam int CNT_W = $clog2(CNT_MOD),
  localparam int SEC_W = $clog2(SEC_MOD),
  localparam int TW    = OFF_W + CNT_W + SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run_en,
  input  logic          master_mode,
  input  logic          ext_mode,
  input  logic          ext_tick,
  input  logic          rx_cs_valid,
  input  logic [TW-1:0] rx_cs_data,
  input  logic          sw_wr,
  input  logic [TW-1:0] sw_data,
  output logic [TW-1:0] timer,
  output logic [TW-1:0] tx_cs_data,
  output logic          cyc_strobe
);
  localparam int CNT_LO = OFF_W;
  localparam int SEC_LO = OFF_W + CNT_W;

  logic [TW-1:0]    timer_q, timer_d;
  logic             strobe_q, strobe_d;
  logic [OFF_W-1:0] off_n;
  logic [CNT_W-1:0] cnt_n;
  logic [SEC_W-1:0] sec_n;
  logic             off_carry, cnt_carry, sec_carry_unused;
  ct_src_e          src;

  iso_ct_stage #(.MOD(OFF_MOD)) u_off (
    .cur   (timer_q[OFF_W-1:0]),
    .inc   (tick_en),
    .clr   (ext_mode & ext_tick),
    .sat   (ext_mode),
    .nxt   (off_n),
    .carry (off_carry)
  );

  iso_ct_stage #(.MOD(CNT_MOD)) u_cnt (
    .cur   (timer_q[SEC_LO-1:CNT_LO]),
    .inc   (off_carry),
    .clr   (1'b0),
    .sat   (1'b0),
    .nxt   (cnt_n),
    .carry (cnt_carry)
  );

  iso_ct_stage #(.MOD(SEC_MOD)) u_sec (
    .cur   (timer_q[TW-1:SEC_LO]),
    .inc   (cnt_carry),
    .clr   (1'b0),
    .sat   (1'b0),
    .nxt   (sec_n),
    .carry (sec_carry_unused)
  );

  iso_ct_sel u_sel (
    .sw_wr    (sw_wr),
    .rx_valid (rx_cs_valid),
    .master   (master_mode),
    .run_en   (run_en),
    .src      (src)
  );

  // Next-state
  always_comb begin
    timer_d  = timer_q;
    strobe_d = 1'b0;
    unique case (src)
      SRC_SW:    timer_d = sw_data;
      SRC_RX:    timer_d = rx_cs_data;
      SRC_COUNT: begin
        timer_d  = {sec_n, cnt_n, off_n};
        strobe_d = off_carry;
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      timer_q  <= timer_d;
      strobe_q <= strobe_d;
    end
  end

  assign timer      = timer_q;
  assign cyc_strobe = strobe_q;
  assign tx_cs_data = master_mode ? timer_q : '0;
endmodule

// File: rtl/iso_ct_chk.sv
module iso_ct_chk #(
  parameter int TW    = 32,
  parameter int OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          run_en,
  input logic          master_mode,
  input logic          ext_tick,
  input logic          rx_cs_valid,
  input logic [TW-1:0] rx_cs_data,
  input logic          sw_wr,
  input logic [TW-1:0] sw_data,
  input logic [TW-1:0] timer,
  input logic          cyc_strobe
);
  a_r3_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |-> (timer[OFF_W-1:0] == '0));

  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !(rx_cs_valid && !master_mode) && !run_en) |=> $stable(timer));

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !(rx_cs_valid && !master_mode) && !tick_en && !ext_tick)
      |=> $stable(timer));

  a_r7_rx_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && rx_cs_valid && !master_mode) |=> (timer == $past(rx_cs_data)));

  a_r10_sw_first: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> ((timer == $past(sw_data)) && !cyc_strobe));

  a_r8_master_ignores_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && rx_cs_valid && !sw_wr && !run_en) |=> $stable(timer));
endmodule

bind iso_cycle_timer iso_ct_chk #(.TW(TW), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .run_en      (run_en),
  .master_mode (master_mode),
  .ext_tick    (ext_tick),
  .rx_cs_valid (rx_cs_valid),
  .rx_cs_data  (rx_cs_data),
  .sw_wr       (sw_wr),
  .sw_data     (sw_data),
  .timer       (timer),
  .cyc_strobe  (cyc_strobe)
);

// File: tb/iso_cycle_timer_tb.sv
`timescale 1ns/1ps
module iso_cycle_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, run_en, master_mode, ext_mode, ext_tick;
  logic        rx_cs_valid, sw_wr;
  logic [31:0] rx_cs_data, sw_data;
  logic [31:0] timer, tx_cs_data;
  logic        cyc_strobe;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_off, m_cnt, m_sec;
  bit m_stb;

  always #2.5 clk = ~clk;

  iso_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .master_mode(master_mode), .ext_mode(ext_mode), .ext_tick(ext_tick),
    .rx_cs_valid(rx_cs_valid), .rx_cs_data(rx_cs_data),
    .sw_wr(sw_wr), .sw_data(sw_data),
    .timer(timer), .tx_cs_data(tx_cs_data), .cyc_strobe(cyc_strobe)
  );

  function automatic logic [31:0] m_val();
    logic [6:0]  s = m_sec[6:0];
    logic [12:0] c = m_cnt[12:0];
    logic [11:0] o = m_off[11:0];
    return {s, c, o};
  endfunction

  task automatic m_load(input logic [31:0] v);
    m_off = int'(v[11:0]);
    m_cnt = int'(v[24:12]);
    m_sec = int'(v[31:25]);
  endtask

  task automatic m_next_cycle();
    if (m_cnt >= 7999) begin
      m_cnt = 0;
      m_sec = (m_sec >= 127) ? 0 : m_sec + 1;
    end else m_cnt = m_cnt + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_off = 0; m_cnt = 0; m_sec = 0; m_stb = 0;
    end else begin
      m_stb = 0;
      if (sw_wr) m_load(sw_data);
      else if (rx_cs_valid && !master_mode) m_load(rx_cs_data);
      else if (run_en) begin
        if (ext_mode && ext_tick) begin
          m_off = 0; m_next_cycle(); m_stb = 1;
        end else if (tick_en) begin
          if (ext_mode) begin
            if (m_off < 3071) m_off = m_off + 1;
          end else if (m_off >= 3071) begin
            m_off = 0; m_next_cycle(); m_stb = 1;
          end else m_off = m_off + 1;
        end
      end
    end
  end

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model, tagged with the active requirement
  task automatic compare();
    check32(cur_req, timer, m_val());
    check32(cur_req, {31'd0, cyc_strobe}, {31'd0, m_stb});
    check32("R8", tx_cs_data, master_mode ? m_val() : 32'd0);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      tick_en = 0; ext_tick = 0; rx_cs_valid = 0; sw_wr = 0;
    end
  endtask

  task automatic swload(input logic [31:0] v);
    sw_wr = 1; sw_data = v; step();
  endtask

  function automatic logic [31:0] pack(input int s, input int c, input int o);
    return (32'(s) << 25) | (32'(c) << 12) | 32'(o);
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; tick_en = 0; run_en = 0; master_mode = 0; ext_mode = 0;
    ext_tick = 0; rx_cs_valid = 0; rx_cs_data = '0; sw_wr = 0; sw_data = '0;
    #12;
    cur_req = "R1";
    check32("R1", timer, 32'd0);
    check32("R1", {31'd0, cyc_strobe}, 32'd0);
    @(negedge clk); rst_n = 1;
    step(2);

    // R2: sparse and back-to-back ticks
    cur_req = "R2"; run_en = 1;
    for (int i = 0; i < 30; i++) begin
      tick_en = (i % 3 != 1); step();
    end
    check32("R2", timer, 32'd20);

    // R3: offset wrap into cycle field with strobe
    cur_req = "R3";
    swload(pack(3, 5, 3069));
    for (int i = 0; i < 4; i++) begin tick_en = 1; step(); end
    check32("R3", timer, pack(3, 6, 1));

    // R4: cycle field wrap into seconds
    cur_req = "R4";
    swload(pack(9, 7999, 3071));
    tick_en = 1; step();
    check32("R4", timer, pack(10, 0, 0));

    // R5: seconds wrap
    cur_req = "R5";
    swload(pack(127, 7999, 3071));
    tick_en = 1; step();
    check32("R5", timer, 32'd0);

    // R6: stopped timer ignores ticks
    cur_req = "R6"; run_en = 0;
    swload(pack(1, 2, 3071));
    for (int i = 0; i < 5; i++) begin tick_en = 1; ext_tick = 1; step(); end
    check32("R6", timer, pack(1, 2, 3071));

    // R7: reload as non-master, stopped and running
    cur_req = "R7";
    rx_cs_valid = 1; rx_cs_data = 32'hA5A5_1234; step();
    check32("R7", timer, 32'hA5A5_1234);
    run_en = 1; rx_cs_valid = 1; tick_en = 1; rx_cs_data = pack(4, 100, 200); step();
    check32("R7", timer, pack(4, 100, 200));

    // R8: master ignores received packets, exposes timer
    cur_req = "R8"; master_mode = 1;
    rx_cs_valid = 1; rx_cs_data = 32'hFFFF_FFFF; tick_en = 1; step();
    check32("R8", timer, pack(4, 100, 201));
    check32("R8", tx_cs_data, pack(4, 100, 201));
    run_en = 0; rx_cs_valid = 1; step(3);
    master_mode = 0; run_en = 1; step();
    check32("R8", tx_cs_data, 32'd0);

    // R9: external tick mode
    cur_req = "R9"; ext_mode = 1;
    swload(pack(2, 7, 3068));
    for (int i = 0; i < 6; i++) begin tick_en = 1; step(); end
    check32("R9", timer, pack(2, 7, 3071));
    ext_tick = 1; tick_en = 1; step();
    check32("R9", timer, pack(2, 8, 0));
    check32("R9", {31'd0, cyc_strobe}, 32'd1);
    tick_en = 1; step();
    check32("R9", {31'd0, cyc_strobe}, 32'd0);
    swload(pack(5, 7999, 10));
    ext_tick = 1; step();
    check32("R9", timer, pack(6, 0, 0));
    ext_mode = 0;

    // R10: priority collisions
    cur_req = "R10";
    swload(pack(0, 0, 3071));
    sw_wr = 1; sw_data = pack(1, 1, 1); rx_cs_valid = 1; rx_cs_data = pack(2, 2, 2);
    tick_en = 1; step();
    check32("R10", timer, pack(1, 1, 1));
    swload(pack(0, 3, 3071));
    rx_cs_valid = 1; rx_cs_data = pack(3, 3, 3071); tick_en = 1; step();
    check32("R10", timer, pack(3, 3, 3071));
    check32("R10", {31'd0, cyc_strobe}, 32'd0);

    // Mixed run
    cur_req = "R3";
    swload(pack(0, 0, 3000));
    for (int i = 0; i < 400; i++) begin tick_en = (i % 5 != 0); step(); end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule